// File: doc/BRIEF.md
# Calendar Real-Time Clock Register Block

This block keeps wall-clock date and time in two packed 32-bit words and offers eight general-purpose retention words. Software reaches all of them through a simple word-wide register bus that covers a 1 KiB window. A one-cycle pulse on the 1 Hz tick input advances the clock. The pulse moves seconds, minutes and hours forward. At midnight it moves the weekday and the calendar date forward, and the date step accounts for month lengths and leap years.

Software sets the clock by writing the date and time words directly. Each of these writes raises a sticky pending flag in a control word. A read of the control word returns the flags and clears them, so a driver can see which calendar fields were written since it last looked. The year is kept as an offset from a base year, which is set by a parameter. Leap-year decisions use the real year, formed as the base year plus the offset.

Top module: `rtc_cal_top`

## Requirements
- R1: Offsets in the window are: control word at 0x000, date word at 0x010, time word at 0x014, and general-purpose word i at 0x100 + 4*i for i = 0..7. Read data is combinational and valid in the same cycle that `bus_rd_en` is high. It is zero while `bus_rd_en` is low. A word written to the date, time or a general-purpose offset reads back unchanged.
- R2: A write to the date word sets control bit 7, and a write to the time word sets control bit 8. All other control bits always read zero.
- R3: A read of the control word returns the current flags. The clock edge that ends the read then clears both flags.
- R4: The date word holds the year offset in bits 31:16, the month (1 to 12) in bits 15:8 and the day of month (1 to 31) in bits 7:0. The time word holds the weekday in bits 31:29 (0 is Monday, 6 is Sunday), the hour in bits 28:16, the minute in bits 15:8 and the second in bits 7:0.
- R5: Each tick increments the second. A second of 59 wraps to 0 and carries into the minute. A minute of 59 wraps the same way into the hour, and an hour of 23 wraps to 0.
- R6: When the hour wraps, the weekday increments, with 6 wrapping to 0, and the day of month increments. After the last day of a month the day becomes 1 and the month increments. After month 12 the month becomes 1 and the year offset increments.
- R7: February has 29 days when the real year (base year plus offset) is divisible by 4, except for century years not divisible by 400. Otherwise it has 28 days. April, June, September and November have 30 days.
- R8: General-purpose words are plain storage and do not change on ticks.
- R9: Reads of addresses at or above 0x400, of unaligned addresses and of unmapped offsets return zero. Writes to such addresses change no state and set no flag. Writes to the control word are also ignored.
- R10: After reset, every word reads zero.
- R11: When a bus write to the date or time word occurs in the same cycle as a tick, the written value is stored and that tick has no effect on that word. If the time word is written in that cycle, no day carry reaches the date word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1hz | input | 1 | One-cycle pulse per second |
| bus_addr | input | ADDR_W (12) | Byte address |
| bus_wr_en | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd_en | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, combinational |

## Verification
The tick path is driven from several starting times: a plain second step, a step that carries into the hour, a step that wraps the year at midnight on New Year's Eve, and several end-of-February steps. The February steps use an ordinary year, a year divisible by 4, a century year and a year divisible by 400. Together these separate the four leap-year outcomes and separate 30-day month handling from 31-day month handling. Flag behaviour is tried with date-only, time-only and combined writes, each followed by two control reads, which separates the set path from the clear path. Collisions between a tick and a write, and accesses that alias into the window, fall outside it or are unaligned, show whether the bus takes priority and whether decoding is exact.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

    localparam int unsigned WORD_W     = 32;
    localparam int unsigned WIN_BITS   = 10;
    localparam logic [9:0]  OFF_CTRL   = 10'h000;
    localparam logic [9:0]  OFF_DATE   = 10'h010;
    localparam logic [9:0]  OFF_TIME   = 10'h014;
    localparam logic [9:0]  OFF_GPBASE = 10'h100;
    localparam int unsigned PEND_DATE_BIT = 7;
    localparam int unsigned PEND_TIME_BIT = 8;

    typedef struct packed {
        logic [15:0] year_ofs;
        logic [7:0]  month;
        logic [7:0]  mday;
    } cal_date_t;

    typedef struct packed {
        logic [2:0]  wday;
        logic [12:0] hour;
        logic [7:0]  minute;
        logic [7:0]  second;
    } cal_time_t;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_CTRL,
        TGT_DATE,
        TGT_TIME,
        TGT_GP
    } reg_tgt_e;

    function automatic logic is_leap(input logic [31:0] year);
        return (year % 4 == 0) && ((year % 100 != 0) || (year % 400 == 0));
    endfunction

    function automatic logic [7:0] month_days(input logic [7:0] month,
                                              input logic [31:0] year);
        case (month)
            8'd2:                      return is_leap(year) ? 8'd29 : 8'd28;
            8'd4, 8'd6, 8'd9, 8'd11:   return 8'd30;
            default:                   return 8'd31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_cal_decode.sv
module rtc_cal_decode
    import rtc_cal_pkg::*;
#(
    parameter int unsigned ADDR_W  = 12,
    parameter int unsigned NUM_GPR = 8,
    localparam int unsigned IDX_W  = (NUM_GPR > 1) ? $clog2(NUM_GPR) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_tgt_e          tgt,
    output logic [IDX_W-1:0]  gp_idx
);

    logic             in_window;
    logic [9:0]       off;

    assign off = addr[WIN_BITS-1:0];

    generate
        if (ADDR_W > WIN_BITS) begin : g_upper
            assign in_window = (addr[ADDR_W-1:WIN_BITS] == '0);
        end else begin : g_flat
            assign in_window = 1'b1;
        end
    endgenerate

    always_comb begin
        tgt    = TGT_NONE;
        gp_idx = '0;
        if (in_window) begin
            if (off == OFF_CTRL)      tgt = TGT_CTRL;
            else if (off == OFF_DATE) tgt = TGT_DATE;
            else if (off == OFF_TIME) tgt = TGT_TIME;
            for (int i = 0; i < NUM_GPR; i++) begin
                if (off == OFF_GPBASE + 10'(4 * i)) begin
                    tgt    = TGT_GP;
                    gp_idx = IDX_W'(i);
                end
            end
        end
    end

endmodule

// File: rtl/rtc_cal_clock.sv
module rtc_cal_clock
    import rtc_cal_pkg::*;
#(
    parameter int unsigned BASE_YEAR = 1970
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              wr_date,
    input  logic              wr_time,
    input  logic [WORD_W-1:0] wdata,
    output cal_date_t         date_q,
    output cal_time_t         time_q
);

    cal_date_t   date_nx;
    cal_time_t   time_nx;
    logic        sec_end, min_end, hr_end, day_carry;
    logic [31:0] real_year;

    assign sec_end   = (time_q.second >= 8'd59);
    assign min_end   = (time_q.minute >= 8'd59);
    assign hr_end    = (time_q.hour   >= 13'd23);
    assign day_carry = tick && !wr_time && sec_end && min_end && hr_end;
    assign real_year = 32'(BASE_YEAR) + 32'(date_q.year_ofs);

    always_comb begin
        time_nx = time_q;
        if (wr_time) begin
            time_nx = cal_time_t'(wdata);
        end else if (tick) begin
            if (!sec_end) begin
                time_nx.second = time_q.second + 8'd1;
            end else begin
                time_nx.second = 8'd0;
                if (!min_end) begin
                    time_nx.minute = time_q.minute + 8'd1;
                end else begin
                    time_nx.minute = 8'd0;
                    if (!hr_end) begin
                        time_nx.hour = time_q.hour + 13'd1;
                    end else begin
                        time_nx.hour = 13'd0;
                        time_nx.wday = (time_q.wday >= 3'd6) ? 3'd0
                                                             : time_q.wday + 3'd1;
                    end
                end
            end
        end
    end

    always_comb begin
        date_nx = date_q;
        if (wr_date) begin
            date_nx = cal_date_t'(wdata);
        end else if (day_carry) begin
            if (date_q.mday < month_days(date_q.month, real_year)) begin
                date_nx.mday = date_q.mday + 8'd1;
            end else begin
                date_nx.mday = 8'd1;
                if (date_q.month >= 8'd12) begin
                    date_nx.month    = 8'd1;
                    date_nx.year_ofs = date_q.year_ofs + 16'd1;
                end else begin
                    date_nx.month = date_q.month + 8'd1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            date_q <= '0;
            time_q <= '0;
        end else begin
            date_q <= date_nx;
            time_q <= time_nx;
        end
    end

endmodule

// File: rtl/rtc_cal_gpr.sv
module rtc_cal_gpr
    import rtc_cal_pkg::*;
#(
    parameter int unsigned NUM_GPR = 8,
    localparam int unsigned IDX_W  = (NUM_GPR > 1) ? $clog2(NUM_GPR) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata
);

    logic [WORD_W-1:0] store [NUM_GPR];

    generate
        for (genvar g = 0; g < NUM_GPR; g++) begin : g_word
            always_ff @(posedge clk) begin
                if (rst) begin
                    store[g] <= '0;
                end else if (wr_en && (idx == IDX_W'(g))) begin
                    store[g] <= wdata;
                end
            end
        end
    endgenerate

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_GPR; i++) begin
            if (idx == IDX_W'(i)) rdata = store[i];
        end
    end

endmodule

// File: rtl/rtc_cal_top.sv
module rtc_cal_top
    import rtc_cal_pkg::*;
#(
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned NUM_GPR   = 8,
    parameter int unsigned BASE_YEAR = 1970,
    localparam int unsigned IDX_W    = (NUM_GPR > 1) ? $clog2(NUM_GPR) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_1hz,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr_en,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_rd_en,
    output logic [31:0]       bus_rdata
);

    reg_tgt_e          tgt;
    logic [IDX_W-1:0]  gp_idx;
    logic              wr_date, wr_time, wr_gp, rd_ctrl;
    logic              pend_date, pend_time;
    cal_date_t         date_q;
    cal_time_t         time_q;
    logic [WORD_W-1:0] gp_rdata, ctrl_word;

    rtc_cal_decode #(.ADDR_W(ADDR_W), .NUM_GPR(NUM_GPR)) i_decode (
        .addr   (bus_addr),
        .tgt    (tgt),
        .gp_idx (gp_idx)
    );

    assign wr_date = bus_wr_en && (tgt == TGT_DATE);
    assign wr_time = bus_wr_en && (tgt == TGT_TIME);
    assign wr_gp   = bus_wr_en && (tgt == TGT_GP);
    assign rd_ctrl = bus_rd_en && (tgt == TGT_CTRL);

    rtc_cal_clock #(.BASE_YEAR(BASE_YEAR)) i_clock (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick_1hz),
        .wr_date (wr_date),
        .wr_time (wr_time),
        .wdata   (bus_wdata),
        .date_q  (date_q),
        .time_q  (time_q)
    );

    rtc_cal_gpr #(.NUM_GPR(NUM_GPR)) i_gpr (
        .clk   (clk),
        .rst   (rst),
        .wr_en (wr_gp),
        .idx   (gp_idx),
        .wdata (bus_wdata),
        .rdata (gp_rdata)
    );

    // Sticky pending flags: a set in the same edge as a clear wins.
    always_ff @(posedge clk) begin
        if (rst) begin
            pend_date <= 1'b0;
            pend_time <= 1'b0;
        end else begin
            pend_date <= wr_date || (pend_date && !rd_ctrl);
            pend_time <= wr_time || (pend_time && !rd_ctrl);
        end
    end

    always_comb begin
        ctrl_word = '0;
        ctrl_word[PEND_DATE_BIT] = pend_date;
        ctrl_word[PEND_TIME_BIT] = pend_time;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd_en) begin
            case (tgt)
                TGT_CTRL: bus_rdata = ctrl_word;
                TGT_DATE: bus_rdata = date_q;
                TGT_TIME: bus_rdata = time_q;
                TGT_GP:   bus_rdata = gp_rdata;
                default:  bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/rtc_cal_checker.sv
module rtc_cal_checker #(
    parameter int unsigned ADDR_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              tick_1hz,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr_en,
    input logic [31:0]       bus_wdata,
    input logic              bus_rd_en,
    input logic [31:0]       bus_rdata,
    input logic              pend_date,
    input logic              pend_time,
    input logic [31:0]       date_word,
    input logic [31:0]       time_word
);

    logic hit_date, hit_time, hit_ctrl;
    assign hit_date = (bus_addr == ADDR_W'(16'h010));
    assign hit_time = (bus_addr == ADDR_W'(16'h014));
    assign hit_ctrl = (bus_addr == ADDR_W'(16'h000));

    a_r2_date_flag: assert property (@(posedge clk) disable iff (rst)
        bus_wr_en && hit_date |=> pend_date);

    a_r2_time_flag: assert property (@(posedge clk) disable iff (rst)
        bus_wr_en && hit_time |=> pend_time);

    a_r3_read_clears: assert property (@(posedge clk) disable iff (rst)
        bus_rd_en && hit_ctrl |=> !pend_date && !pend_time);

    a_r11_write_wins: assert property (@(posedge clk) disable iff (rst)
        bus_wr_en && hit_date |=> date_word == $past(bus_wdata));

    a_r5_second_step: assert property (@(posedge clk) disable iff (rst)
        tick_1hz && !(bus_wr_en && hit_time) && (time_word[7:0] < 8'd59)
        |=> time_word[7:0] == $past(time_word[7:0]) + 8'd1);

    a_r9_unaligned_zero: assert property (@(posedge clk) disable iff (rst)
        bus_rd_en && (bus_addr[1:0] != 2'b00) |-> bus_rdata == 32'd0);

    a_r1_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !bus_rd_en |-> bus_rdata == 32'd0);

endmodule

bind rtc_cal_top rtc_cal_checker #(.ADDR_W(ADDR_W)) i_checker (
    .clk       (clk),
    .rst       (rst),
    .tick_1hz  (tick_1hz),
    .bus_addr  (bus_addr),
    .bus_wr_en (bus_wr_en),
    .bus_wdata (bus_wdata),
    .bus_rd_en (bus_rd_en),
    .bus_rdata (bus_rdata),
    .pend_date (pend_date),
    .pend_time (pend_time),
    .date_word (date_q),
    .time_word (time_q)
);

// File: tb/test_rtc_cal_top.sv
module test_rtc_cal_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_1hz = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_wr_en = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd_en = 1'b0;
    logic [31:0] bus_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    localparam logic [11:0] A_CTRL = 12'h000;
    localparam logic [11:0] A_DATE = 12'h010;
    localparam logic [11:0] A_TIME = 12'h014;
    localparam logic [11:0] A_GP0  = 12'h100;

    always #2 clk = ~clk;

    rtc_cal_top i_rtc_cal_top (
        .clk       (clk),
        .rst       (rst),
        .tick_1hz  (tick_1hz),
        .bus_addr  (bus_addr),
        .bus_wr_en (bus_wr_en),
        .bus_wdata (bus_wdata),
        .bus_rd_en (bus_rd_en),
        .bus_rdata (bus_rdata)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [11:0] a, input logic [31:0] d, input logic with_tick);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr_en = 1'b1;
        tick_1hz  = with_tick;
        @(negedge clk);
        bus_wr_en = 1'b0;
        tick_1hz  = 1'b0;
    endtask

    task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_rd_en = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd_en = 1'b0;
    endtask

    task automatic pulse_tick();
        @(negedge clk);
        tick_1hz = 1'b1;
        @(negedge clk);
        tick_1hz = 1'b0;
    endtask

    task automatic expect_rd(input string req, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] v;
        bus_rd(a, v);
        check(req, v, exp);
    endtask

    // Sets date and time, ticks once, checks both words; drains flags.
    task automatic tick_case(input string req, input logic [31:0] d0, input logic [31:0] t0,
                             input logic [31:0] d1, input logic [31:0] t1);
        logic [31:0] v;
        bus_wr(A_DATE, d0, 1'b0);
        bus_wr(A_TIME, t0, 1'b0);
        pulse_tick();
        expect_rd({req, " time"}, A_TIME, t1);
        expect_rd({req, " date"}, A_DATE, d1);
        bus_rd(A_CTRL, v);
    endtask

    task automatic t_reset();
        expect_rd("R10 ctrl", A_CTRL, 32'h0);
        expect_rd("R10 date", A_DATE, 32'h0);
        expect_rd("R10 time", A_TIME, 32'h0);
        expect_rd("R10 gp0", A_GP0, 32'h0);
        expect_rd("R10 gp7", A_GP0 + 12'h01C, 32'h0);
    endtask

    task automatic t_idle_zero();
        bus_wr(A_GP0, 32'hDEAD_BEEF, 1'b0);
        @(negedge clk);
        bus_addr = A_GP0;
        #1 check("R1 idle rdata zero", bus_rdata, 32'h0);
    endtask

    task automatic t_gpr();
        for (int i = 0; i < 8; i++) bus_wr(A_GP0 + 12'(4 * i), 32'hA500_0000 + 32'(i * 17), 1'b0);
        for (int i = 0; i < 3; i++) pulse_tick();
        for (int i = 0; i < 8; i++)
            expect_rd("R1 R8 gp readback", A_GP0 + 12'(4 * i), 32'hA500_0000 + 32'(i * 17));
    endtask

    task automatic t_flags();
        logic [31:0] v;
        bus_rd(A_CTRL, v);
        bus_wr(A_DATE, 32'h0035_0C1F, 1'b0);
        expect_rd("R2 date flag", A_CTRL, 32'h0000_0080);
        expect_rd("R3 cleared after read", A_CTRL, 32'h0);
        bus_wr(A_TIME, 32'h0001_0203, 1'b0);
        expect_rd("R2 time flag", A_CTRL, 32'h0000_0100);
        bus_wr(A_DATE, 32'h0001_0101, 1'b0);
        bus_wr(A_TIME, 32'h0, 1'b0);
        expect_rd("R2 both flags", A_CTRL, 32'h0000_0180);
        expect_rd("R3 both cleared", A_CTRL, 32'h0);
        expect_rd("R1 R4 date readback", A_DATE, 32'h0001_0101);
    endtask

    task automatic t_time_steps();
        tick_case("R5 second step", 32'h0035_0603, 32'h0000_0005, 32'h0035_0603, 32'h0000_0006);
        tick_case("R5 hour carry", 32'h0035_0603, 32'h400A_3B3B, 32'h0035_0603, 32'h400B_0000);
        tick_case("R6 new year", 32'h0035_0C1F, 32'hC017_3B3B, 32'h0036_0101, 32'h0000_0000);
        tick_case("R6 mid month", 32'h0035_030A, 32'h6017_3B3B, 32'h0035_030B, 32'h8000_0000);
    endtask

    task automatic t_leap();
        tick_case("R7 leap 2024", 32'h0036_021C, 32'h0017_3B3B, 32'h0036_021D, 32'h2000_0000);
        tick_case("R7 common 2023", 32'h0035_021C, 32'h0017_3B3B, 32'h0035_0301, 32'h2000_0000);
        tick_case("R7 century 2100", 32'h0082_021C, 32'h0017_3B3B, 32'h0082_0301, 32'h2000_0000);
        tick_case("R7 quad century 2000", 32'h001E_021C, 32'h0017_3B3B, 32'h001E_021D, 32'h2000_0000);
        tick_case("R7 leap day end", 32'h0036_021D, 32'h0017_3B3B, 32'h0036_0301, 32'h2000_0000);
        tick_case("R7 april end", 32'h0035_041E, 32'h0017_3B3B, 32'h0035_0501, 32'h2000_0000);
    endtask

    task automatic t_collide();
        logic [31:0] v;
        bus_wr(A_DATE, 32'h0035_0C1F, 1'b0);
        bus_wr(A_TIME, 32'h0000_0005, 1'b0);
        bus_wr(A_TIME, 32'hC017_3B3B, 1'b1);
        expect_rd("R11 time write beats tick", A_TIME, 32'hC017_3B3B);
        expect_rd("R11 no day carry", A_DATE, 32'h0035_0C1F);
        bus_wr(A_TIME, 32'h0000_0005, 1'b0);
        bus_wr(A_DATE, 32'h0035_0A0A, 1'b1);
        expect_rd("R11 date write stored", A_DATE, 32'h0035_0A0A);
        expect_rd("R11 time still ticks", A_TIME, 32'h0000_0006);
        bus_rd(A_CTRL, v);
    endtask

    task automatic t_bad_addr();
        bus_wr(A_DATE, 32'h0035_0707, 1'b0);
        bus_wr(A_TIME, 32'h0001_0101, 1'b0);
        expect_rd("R9 drain", A_CTRL, 32'h0000_0180);
        bus_wr(12'h410, 32'h1111_1111, 1'b0);
        bus_wr(12'h012, 32'h2222_2222, 1'b0);
        bus_wr(12'h120, 32'h3333_3333, 1'b0);
        bus_wr(A_CTRL, 32'hFFFF_FFFF, 1'b0);
        expect_rd("R9 no flags from ignored writes", A_CTRL, 32'h0);
        expect_rd("R9 date unchanged", A_DATE, 32'h0035_0707);
        expect_rd("R9 time unchanged", A_TIME, 32'h0001_0101);
        expect_rd("R9 gp0 unchanged", A_GP0, 32'hA500_0000);
        expect_rd("R9 alias read zero", 12'h410, 32'h0);
        expect_rd("R9 unaligned read zero", 12'h011, 32'h0);
        expect_rd("R9 unmapped read zero", 12'h020, 32'h0);
        expect_rd("R9 past gp range zero", 12'h120, 32'h0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_idle_zero();
        t_gpr();
        t_flags();
        t_time_steps();
        t_leap();
        t_collide();
        t_bad_addr();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule